// File: doc/BRIEF.md
# Selectable Pattern RAM Self-Test Controller

This block is a self-test engine for an on-chip byte RAM of 32K locations, stored as words of four byte lanes. Four consecutive byte locations are therefore one word that is written or compared in a single access. Software picks one of several test algorithms with a 3-bit select field and sets a start bit in a small control register. The start is taken only while the device mode input holds the run value. Once started, the engine takes over the RAM port from the host and runs the chosen algorithm over the whole array. It then raises a pass flag or a fail flag and clears the start bit itself.

Three algorithms exist. The first fills the array with an address-derived pattern and then reads it all back. The second replaces every word with the ones complement of what it held. The third marches through the array one word at a time with four nibble patterns. The engine stops at the first miscompare and latches the index of the failing word, which is the group of four byte addresses. Software reads that index back through a low and a high register. Select codes that name no algorithm finish at once with a pass.

Top module: `ram_selftest`

## Requirements
- R1: A control write (register 0) with bit 3 set starts a test only when `mode_i` equals 4 and no test is running. With any other mode value, the start bit stays 0, the pass and fail flags keep their values, and the RAM is not touched.
- R2: Control register 0 reads as {bit 7 = 0, bits 6:4 = select, bit 3 = running, bit 2 = 0, bit 1 = fail, bit 0 = pass}. Bit 3 reads 1 while a test runs and clears by itself when the test ends.
- R3: Accepting a start clears both the pass flag and the fail flag, so they read 0 in the cycle after the start write.
- R4: Select 0 (incrementing) writes every word in ascending order. Lane k of word w receives the low 8 bits of byte address 4w+k. The test then reads every word back and compares it, and on a fault-free RAM it ends with pass set and that pattern left in the RAM.
- R5: Select 1 (complement) reads each word, writes back its ones complement and verifies the written value. On a fault-free RAM every word ends as the complement of its prior contents, with pass set.
- R6: Select 2 (march) handles one word at a time. It writes 0xF0, 0x00, 0x0F and 0xFF to all four lanes in that order and verifies each one before the next, then moves to the next word. On a fault-free RAM it leaves every word at 0xFFFFFFFF with pass set, and a stuck bit anywhere in a word makes it fail.
- R7: At the first miscompare the test stops and sets fail with pass clear. Register 1 then holds bits 7:0 of the failing word index, and register 2 holds bits 15:8. Both hold until the next accepted start, which clears them to 0.
- R8: Select codes 3 to 7 end the test within two cycles of the start, with pass set and the RAM untouched.
- R9: While a test runs, host RAM requests are ignored. While no test runs, host requests drive the RAM port, and host read data is the RAM read data.
- R10: After reset, registers 0 to 2 read 0, and the RAM port is idle while no test or host request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Device operating mode; start is accepted only at value 4 |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register index: 0 control/status, 1 fail low, 2 fail high |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i (combinational) |
| host_req_i | input | 1 | Host RAM access request |
| host_we_i | input | 1 | Host RAM write enable |
| host_addr_i | input | WORD_AW | Host RAM word address |
| host_wdata_i | input | LANES*BYTE_W | Host RAM write data |
| host_rdata_o | output | LANES*BYTE_W | Host RAM read data |
| mem_en_o | output | 1 | RAM access enable |
| mem_we_o | output | 1 | RAM write enable |
| mem_addr_o | output | WORD_AW | RAM word address |
| mem_wdata_o | output | LANES*BYTE_W | RAM write data |
| mem_rdata_i | input | LANES*BYTE_W | RAM read data, one cycle after a read |

## Verification
Each algorithm first runs on a fault-free RAM model, and the whole array is then compared with the image the requirement predicts. This shows that the right pattern was written to each lane and in the right order. Faults are then injected as single stuck-at-0 and stuck-at-1 bits at the first word, the last word and words whose index needs the high fail register. These runs show whether the engine stops on the correct group and whether a fault is caught by the pattern in question: the incrementing pass misses a stuck bit that already matches its data, and the march pass does not. Further directed runs try a start in the wrong mode, undefined select codes, and host traffic during and after a run.

// File: rtl/ram_selftest_pkg.sv
package ram_selftest_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_WRITE,
      ST_READ,
      ST_CAPT,
      ST_CHECK,
      ST_FIN
   } st_state_e;

   typedef enum logic [1:0] {
      ALG_INC,
      ALG_CPL,
      ALG_MARCH,
      ALG_NONE
   } st_alg_e;

   function automatic st_alg_e decode_sel(input logic [2:0] s);
      case (s)
         3'd0:    return ALG_INC;
         3'd1:    return ALG_CPL;
         3'd2:    return ALG_MARCH;
         default: return ALG_NONE;
      endcase
   endfunction

endpackage

// File: rtl/ram_selftest_patgen.sv
module ram_selftest_patgen
   import ram_selftest_pkg::*;
#(
   parameter int WORD_AW = 13,
   parameter int LANES   = 4,
   parameter int BYTE_W  = 8,
   localparam int DATA_W  = LANES * BYTE_W,
   localparam int LANE_AW = (LANES > 1) ? $clog2(LANES) : 1,
   localparam int HALF_W  = BYTE_W / 2
) (
   input  st_alg_e              alg_i,
   input  logic [WORD_AW-1:0]   addr_i,
   input  logic [1:0]           pidx_i,
   input  logic [DATA_W-1:0]    hold_i,
   output logic [DATA_W-1:0]    pat_o
);

   if ((BYTE_W % 2) != 0) begin : g_bad_byte
      $error("BYTE_W must be even");
   end

   logic [DATA_W-1:0] inc_word;
   logic [DATA_W-1:0] march_word;
   logic [BYTE_W-1:0] march_byte;

   always_comb begin
      case (pidx_i)
         2'd0:    march_byte = {{(BYTE_W-HALF_W){1'b1}}, {HALF_W{1'b0}}};
         2'd1:    march_byte = '0;
         2'd2:    march_byte = {{(BYTE_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
         default: march_byte = '1;
      endcase
   end

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign inc_word[k*BYTE_W +: BYTE_W]   = BYTE_W'({addr_i, LANE_AW'(k)});
      assign march_word[k*BYTE_W +: BYTE_W] = march_byte;
   end

   always_comb begin
      case (alg_i)
         ALG_INC:   pat_o = inc_word;
         ALG_CPL:   pat_o = hold_i;
         ALG_MARCH: pat_o = march_word;
         default:   pat_o = '0;
      endcase
   end

endmodule

// File: rtl/ram_selftest_seq.sv
module ram_selftest_seq
   import ram_selftest_pkg::*;
#(
   parameter int WORD_AW = 13,
   parameter int DATA_W  = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [2:0]         sel_i,
   input  logic [DATA_W-1:0]  pat_i,
   input  logic [DATA_W-1:0]  mem_rdata_i,
   output st_alg_e            alg_o,
   output logic [WORD_AW-1:0] addr_o,
   output logic [1:0]         pidx_o,
   output logic [DATA_W-1:0]  hold_o,
   output logic               active_o,
   output logic               mem_en_o,
   output logic               mem_we_o,
   output logic               done_o,
   output logic               res_pass_o,
   output logic               res_fail_o
);

   st_state_e          state_q;
   st_alg_e            alg_q;
   logic [WORD_AW-1:0] addr_q;
   logic [1:0]         pidx_q;
   logic               rb_q;
   logic [DATA_W-1:0]  hold_q;

   logic last_word, mismatch, finishing;

   assign last_word = (addr_q == {WORD_AW{1'b1}});
   assign mismatch  = (mem_rdata_i != pat_i);
   assign finishing = last_word && ((alg_q != ALG_MARCH) || (pidx_q == 2'd3));

   assign alg_o    = alg_q;
   assign addr_o   = addr_q;
   assign pidx_o   = pidx_q;
   assign hold_o   = hold_q;
   assign active_o = (state_q != ST_IDLE);
   assign mem_en_o = (state_q == ST_WRITE) || (state_q == ST_READ);
   assign mem_we_o = (state_q == ST_WRITE);

   always_comb begin
      done_o     = 1'b0;
      res_pass_o = 1'b0;
      res_fail_o = 1'b0;
      if (state_q == ST_FIN) begin
         done_o     = 1'b1;
         res_pass_o = 1'b1;
      end else if (state_q == ST_CHECK) begin
         if (mismatch) begin
            done_o     = 1'b1;
            res_fail_o = 1'b1;
         end else if (finishing) begin
            done_o     = 1'b1;
            res_pass_o = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         alg_q   <= ALG_NONE;
         addr_q  <= '0;
         pidx_q  <= '0;
         rb_q    <= 1'b0;
         hold_q  <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  alg_q  <= decode_sel(sel_i);
                  addr_q <= '0;
                  pidx_q <= '0;
                  rb_q   <= 1'b0;
                  case (decode_sel(sel_i))
                     ALG_NONE: state_q <= ST_FIN;
                     ALG_CPL:  state_q <= ST_READ;
                     default:  state_q <= ST_WRITE;
                  endcase
               end
            end
            ST_WRITE: begin
               if (alg_q == ALG_INC) begin
                  if (last_word) begin
                     addr_q  <= '0;
                     state_q <= ST_READ;
                  end else begin
                     addr_q <= addr_q + 1'b1;
                  end
               end else begin
                  state_q <= ST_READ;
               end
            end
            ST_READ: begin
               state_q <= (alg_q == ALG_CPL && !rb_q) ? ST_CAPT : ST_CHECK;
            end
            ST_CAPT: begin
               hold_q  <= ~mem_rdata_i;
               rb_q    <= 1'b1;
               state_q <= ST_WRITE;
            end
            ST_CHECK: begin
               if (mismatch || finishing) begin
                  state_q <= ST_IDLE;
               end else begin
                  case (alg_q)
                     ALG_MARCH: begin
                        state_q <= ST_WRITE;
                        if (pidx_q == 2'd3) begin
                           pidx_q <= '0;
                           addr_q <= addr_q + 1'b1;
                        end else begin
                           pidx_q <= pidx_q + 1'b1;
                        end
                     end
                     default: begin
                        rb_q    <= 1'b0;
                        addr_q  <= addr_q + 1'b1;
                        state_q <= ST_READ;
                     end
                  endcase
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/ram_selftest_regs.sv
module ram_selftest_regs #(
   parameter int         WORD_AW  = 13,
   parameter logic [2:0] RUN_MODE = 3'd4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [2:0]         mode_i,
   input  logic               wr_i,
   input  logic [1:0]         addr_i,
   input  logic [7:0]         wdata_i,
   output logic [7:0]         rdata_o,
   input  logic               done_i,
   input  logic               res_pass_i,
   input  logic               res_fail_i,
   input  logic [WORD_AW-1:0] grp_i,
   output logic               start_o,
   output logic [2:0]         sel_o,
   output logic               busy_o,
   output logic               pass_o,
   output logic               fail_o,
   output logic [WORD_AW-1:0] grp_o
);

   localparam logic [1:0] REG_CTRL = 2'd0;
   localparam logic [1:0] REG_GLO  = 2'd1;
   localparam logic [1:0] REG_GHI  = 2'd2;
   localparam int         START_B  = 3;

   if (WORD_AW > 16 || WORD_AW < 1) begin : g_bad_aw
      $error("WORD_AW must be within 1..16");
   end

   logic        ctrl_wr;
   logic [15:0] grp_ext;
   logic [7:0]  grp_hi;
   logic        unused_wbits;

   assign ctrl_wr      = wr_i && (addr_i == REG_CTRL) && !busy_o;
   assign start_o      = ctrl_wr && wdata_i[START_B] && (mode_i == RUN_MODE);
   assign grp_ext      = 16'(grp_o);
   assign unused_wbits = ^{wdata_i[7], wdata_i[2:0]};

   if (WORD_AW > 8) begin : g_hi_used
      assign grp_hi = grp_ext[15:8];
   end else begin : g_hi_zero
      assign grp_hi = 8'h00;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_o  <= '0;
         busy_o <= 1'b0;
         pass_o <= 1'b0;
         fail_o <= 1'b0;
         grp_o  <= '0;
      end else begin
         if (ctrl_wr) sel_o <= wdata_i[6:4];
         if (start_o) begin
            busy_o <= 1'b1;
            pass_o <= 1'b0;
            fail_o <= 1'b0;
            grp_o  <= '0;
         end else if (done_i) begin
            busy_o <= 1'b0;
            pass_o <= res_pass_i;
            fail_o <= res_fail_i;
            if (res_fail_i) grp_o <= grp_i;
         end
      end
   end

   always_comb begin
      case (addr_i)
         REG_CTRL: rdata_o = {1'b0, sel_o, busy_o, 1'b0, fail_o, pass_o};
         REG_GLO:  rdata_o = grp_ext[7:0];
         REG_GHI:  rdata_o = grp_hi;
         default:  rdata_o = 8'h00;
      endcase
   end

endmodule

// File: rtl/ram_selftest_portmux.sv
module ram_selftest_portmux #(
   parameter int WORD_AW = 13,
   parameter int DATA_W  = 32
) (
   input  logic               own_i,
   input  logic               seq_en_i,
   input  logic               seq_we_i,
   input  logic [WORD_AW-1:0] seq_addr_i,
   input  logic [DATA_W-1:0]  seq_wdata_i,
   input  logic               host_req_i,
   input  logic               host_we_i,
   input  logic [WORD_AW-1:0] host_addr_i,
   input  logic [DATA_W-1:0]  host_wdata_i,
   output logic               mem_en_o,
   output logic               mem_we_o,
   output logic [WORD_AW-1:0] mem_addr_o,
   output logic [DATA_W-1:0]  mem_wdata_o
);

   always_comb begin
      if (own_i) begin
         mem_en_o    = seq_en_i;
         mem_we_o    = seq_we_i;
         mem_addr_o  = seq_addr_i;
         mem_wdata_o = seq_wdata_i;
      end else begin
         mem_en_o    = host_req_i;
         mem_we_o    = host_req_i && host_we_i;
         mem_addr_o  = host_addr_i;
         mem_wdata_o = host_wdata_i;
      end
   end

endmodule

// File: rtl/ram_selftest.sv
module ram_selftest
   import ram_selftest_pkg::*;
#(
   parameter int         WORD_AW  = 13,
   parameter int         LANES    = 4,
   parameter int         BYTE_W   = 8,
   parameter logic [2:0] RUN_MODE = 3'd4,
   localparam int        DATA_W   = LANES * BYTE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [2:0]         mode_i,
   input  logic               reg_wr_i,
   input  logic [1:0]         reg_addr_i,
   input  logic [7:0]         reg_wdata_i,
   output logic [7:0]         reg_rdata_o,
   input  logic               host_req_i,
   input  logic               host_we_i,
   input  logic [WORD_AW-1:0] host_addr_i,
   input  logic [DATA_W-1:0]  host_wdata_i,
   output logic [DATA_W-1:0]  host_rdata_o,
   output logic               mem_en_o,
   output logic               mem_we_o,
   output logic [WORD_AW-1:0] mem_addr_o,
   output logic [DATA_W-1:0]  mem_wdata_o,
   input  logic [DATA_W-1:0]  mem_rdata_i
);

   if (LANES < 1 || (LANES & (LANES - 1)) != 0) begin : g_bad_lanes
      $error("LANES must be a power of two");
   end

   st_alg_e            alg;
   logic [WORD_AW-1:0] seq_addr, fail_grp;
   logic [1:0]         pidx;
   logic [DATA_W-1:0]  hold, pat;
   logic               start, busy, flag_pass, flag_fail;
   logic               seq_active, seq_en, seq_we;
   logic               done, res_pass, res_fail;
   logic [2:0]         sel;

   ram_selftest_regs #(.WORD_AW(WORD_AW), .RUN_MODE(RUN_MODE)) regs_i (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
      .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
      .done_i(done), .res_pass_i(res_pass), .res_fail_i(res_fail), .grp_i(seq_addr),
      .start_o(start), .sel_o(sel), .busy_o(busy),
      .pass_o(flag_pass), .fail_o(flag_fail), .grp_o(fail_grp)
   );

   ram_selftest_seq #(.WORD_AW(WORD_AW), .DATA_W(DATA_W)) seq_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .sel_i(reg_wdata_i[6:4]),
      .pat_i(pat), .mem_rdata_i(mem_rdata_i),
      .alg_o(alg), .addr_o(seq_addr), .pidx_o(pidx), .hold_o(hold),
      .active_o(seq_active), .mem_en_o(seq_en), .mem_we_o(seq_we),
      .done_o(done), .res_pass_o(res_pass), .res_fail_o(res_fail)
   );

   ram_selftest_patgen #(.WORD_AW(WORD_AW), .LANES(LANES), .BYTE_W(BYTE_W)) pat_i (
      .alg_i(alg), .addr_i(seq_addr), .pidx_i(pidx), .hold_i(hold), .pat_o(pat)
   );

   ram_selftest_portmux #(.WORD_AW(WORD_AW), .DATA_W(DATA_W)) mux_i (
      .own_i(seq_active), .seq_en_i(seq_en), .seq_we_i(seq_we),
      .seq_addr_i(seq_addr), .seq_wdata_i(pat),
      .host_req_i(host_req_i), .host_we_i(host_we_i),
      .host_addr_i(host_addr_i), .host_wdata_i(host_wdata_i),
      .mem_en_o(mem_en_o), .mem_we_o(mem_we_o),
      .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o)
   );

   assign host_rdata_o = mem_rdata_i;

endmodule

// File: rtl/ram_selftest_chk.sv
module ram_selftest_chk #(
   parameter int         WORD_AW  = 13,
   parameter logic [2:0] RUN_MODE = 3'd4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [2:0]         mode_i,
   input logic               busy,
   input logic               flag_pass,
   input logic               flag_fail,
   input logic [WORD_AW-1:0] fail_grp,
   input logic               seq_active,
   input logic               host_req_i,
   input logic               mem_en_o,
   input logic [2:0]         sel
);

   assert_start_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(mode_i) == RUN_MODE));

   assert_start_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (!flag_pass && !flag_fail));

   assert_one_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (flag_pass != flag_fail));

   assert_sel_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(sel));

   assert_flags_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(flag_pass && flag_fail));

   assert_grp_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy)) |-> $stable(fail_grp));

   assert_owner_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy == seq_active);

   assert_port_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!seq_active && !host_req_i) |-> !mem_en_o);

endmodule

bind ram_selftest ram_selftest_chk #(.WORD_AW(WORD_AW), .RUN_MODE(RUN_MODE)) chk_i (
   .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .busy(busy),
   .flag_pass(flag_pass), .flag_fail(flag_fail), .fail_grp(fail_grp),
   .seq_active(seq_active), .host_req_i(host_req_i), .mem_en_o(mem_en_o), .sel(sel)
);

// File: tb/ram_selftest_tb_top.sv
`timescale 1ns/1ps
module ram_selftest_tb_top;

   localparam int WAW   = 10;
   localparam int DW    = 32;
   localparam int WORDS = 1 << WAW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    mode = 3'd4;
   logic          reg_wr = 1'b0;
   logic [1:0]    reg_addr = '0;
   logic [7:0]    reg_wdata = '0;
   logic [7:0]    reg_rdata;
   logic          host_req = 1'b0, host_we = 1'b0;
   logic [WAW-1:0] host_addr = '0;
   logic [DW-1:0] host_wdata = '0, host_rdata;
   logic          mem_en, mem_we;
   logic [WAW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata, mem_rdata;

   logic [DW-1:0] ram [WORDS];
   logic          flt_on = 1'b0;
   logic [WAW-1:0] flt_word = '0;
   logic [DW-1:0] flt_s0 = '0, flt_s1 = '0;

   int checks = 0, failures = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   ram_selftest #(.WORD_AW(WAW)) dut_i (
      .clk(clk), .rst_n(rst_n), .mode_i(mode),
      .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
      .host_req_i(host_req), .host_we_i(host_we), .host_addr_i(host_addr),
      .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
      .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
      .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
   );

   // behavioural RAM with optional stuck bits in one word
   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) begin
            if (flt_on && mem_addr == flt_word)
               ram[mem_addr] <= (mem_wdata & ~flt_s0) | flt_s1;
            else
               ram[mem_addr] <= mem_wdata;
         end else begin
            mem_rdata <= ram[mem_addr];
         end
      end
   end

   typedef struct packed {
      logic [2:0]     sel;
      logic [1:0]     pre;      // 0 keep, 1 address pattern, 2 zeros
      logic           flt;
      logic [WAW-1:0] fw;
      logic [DW-1:0]  s0;
      logic [DW-1:0]  s1;
      logic           exp_fail;
      logic [WAW-1:0] exp_grp;
      logic [3:0]     req;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{3'd0, 2'd0, 1'b0, 10'd0,    32'h0,        32'h0, 1'b0, 10'd0,    4'd4}, // R4 clean
      '{3'd2, 2'd0, 1'b0, 10'd0,    32'h0,        32'h0, 1'b0, 10'd0,    4'd6}, // R6 clean
      '{3'd1, 2'd1, 1'b0, 10'd0,    32'h0,        32'h0, 1'b0, 10'd0,    4'd5}, // R5 clean
      '{3'd0, 2'd0, 1'b1, 10'd677,  32'h0000_1000, 32'h0, 1'b1, 10'd677,  4'd7}, // R7 high byte
      '{3'd0, 2'd0, 1'b1, 10'd1023, 32'h0, 32'h0000_0001, 1'b1, 10'd1023, 4'd7}, // R7 last word
      '{3'd0, 2'd0, 1'b1, 10'd0,    32'h0000_0100, 32'h0, 1'b1, 10'd0,    4'd7}, // R7 first word
      '{3'd2, 2'd0, 1'b1, 10'd600,  32'h8000_0000, 32'h0, 1'b1, 10'd600,  4'd6}, // R6 fault
      '{3'd1, 2'd2, 1'b1, 10'd5,    32'h0000_0080, 32'h0, 1'b1, 10'd5,    4'd5}, // R5 fault
      '{3'd5, 2'd0, 1'b0, 10'd0,    32'h0,        32'h0, 1'b0, 10'd0,    4'd8}, // R8
      '{3'd7, 2'd0, 1'b0, 10'd0,    32'h0,        32'h0, 1'b0, 10'd0,    4'd8}  // R8
   };

   function automatic logic [DW-1:0] pre_pat(input int a);
      logic [7:0] lo;
      lo = 8'(a);
      return {lo ^ 8'hA5, ~lo, 6'b0, 2'(a >> 8), 8'h3C};
   endfunction

   function automatic logic [DW-1:0] inc_pat(input int w);
      return {8'(4*w+3), 8'(4*w+2), 8'(4*w+1), 8'(4*w)};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_done(output int iters, output logic [7:0] st);
      iters = 0;
      do begin
         reg_read(2'd0, st);
         iters++;
      end while (st[3] && iters < 60000);
   endtask

   // watchdog
   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [7:0] st, lo, hi;
      int iters, bad, first_bad;
      logic [DW-1:0] exp_w;
      for (int i = 0; i < WORDS; i++) ram[i] = '0;
      mem_rdata = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R10 reset state
      reg_read(2'd0, st); chk(st == 8'h00, "R10 ctrl after reset", DW'(st), 0);
      reg_read(2'd1, lo); chk(lo == 8'h00, "R10 grp lo after reset", DW'(lo), 0);
      reg_read(2'd2, hi); chk(hi == 8'h00, "R10 grp hi after reset", DW'(hi), 0);
      chk(mem_en == 1'b0, "R10 port idle", DW'(mem_en), 0);

      // vector walk
      for (int v = 0; v < NV; v++) begin
         string tg;
         tg = $sformatf("R%0d vec%0d", VECS[v].req, v);
         if (VECS[v].pre == 2'd1) for (int i = 0; i < WORDS; i++) ram[i] = pre_pat(i);
         if (VECS[v].pre == 2'd2) for (int i = 0; i < WORDS; i++) ram[i] = '0;
         flt_on = VECS[v].flt; flt_word = VECS[v].fw;
         flt_s0 = VECS[v].s0;  flt_s1 = VECS[v].s1;
         reg_write(2'd0, {1'b0, VECS[v].sel, 1'b1, 3'b000});
         wait_done(iters, st);
         exp_w = DW'({1'b0, VECS[v].sel, 2'b00, VECS[v].exp_fail, !VECS[v].exp_fail});
         chk(st == exp_w[7:0], {tg, " status"}, DW'(st), exp_w);
         if (VECS[v].req == 4'd8)
            chk(iters <= 2, {tg, " R8 latency"}, DW'(iters), 2);
         repeat (10) @(negedge clk);
         reg_read(2'd1, lo); reg_read(2'd2, hi);
         chk({hi, lo} == 16'(VECS[v].exp_grp), {tg, " R7 group"}, DW'({hi, lo}), DW'(VECS[v].exp_grp));
         if (!VECS[v].exp_fail && VECS[v].sel < 3'd3) begin
            bad = 0; first_bad = -1;
            for (int i = 0; i < WORDS; i++) begin
               case (VECS[v].sel)
                  3'd0:    exp_w = inc_pat(i);
                  3'd1:    exp_w = ~pre_pat(i);
                  default: exp_w = '1;
               endcase
               if (ram[i] !== exp_w) begin
                  bad++;
                  if (first_bad < 0) first_bad = i;
               end
            end
            chk(bad == 0, {tg, " RAM image"}, DW'(bad), 0);
         end
         flt_on = 1'b0;
      end

      // R1: start outside mode 4 ignored
      ram[0] = 32'hDEAD_BEEF;
      mode = 3'd3;
      reg_write(2'd0, 8'h08);
      repeat (8) @(negedge clk);
      reg_read(2'd0, st);
      chk(st == 8'h01, "R1 start ignored, flags kept", DW'(st), 32'h01);
      chk(ram[0] == 32'hDEAD_BEEF, "R1 RAM untouched", ram[0], 32'hDEAD_BEEF);
      mode = 3'd4;

      // R2/R3: running bit and cleared flags right after start
      reg_write(2'd0, 8'h28);
      reg_read(2'd0, st);
      chk(st == 8'h28, "R3 flags cleared, R2 running bit", DW'(st), 32'h28);
      // R9: host write during run is ignored
      repeat (100) @(negedge clk);
      host_req = 1'b1; host_we = 1'b1; host_addr = 10'd3; host_wdata = 32'h1234_5678;
      @(negedge clk);
      host_req = 1'b0; host_we = 1'b0;
      wait_done(iters, st);
      chk(st == 8'h21, "R2 start bit self-cleared with pass", DW'(st), 32'h21);
      chk(ram[3] == 32'hFFFF_FFFF, "R9 host write blocked during run", ram[3], 32'hFFFF_FFFF);
      // R9: host access when idle
      @(negedge clk);
      host_req = 1'b1; host_we = 1'b1; host_addr = 10'd3; host_wdata = 32'h1234_5678;
      @(negedge clk);
      host_we = 1'b0;
      @(negedge clk);
      host_req = 1'b0;
      chk(ram[3] == 32'h1234_5678, "R9 host write when idle", ram[3], 32'h1234_5678);
      chk(host_rdata == 32'h1234_5678, "R9 host read when idle", host_rdata, 32'h1234_5678);

      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule